// File: doc/BRIEF.md
# Binary Code Modulation Shift-Register Driver

This block dims 32 on/off outputs that sit behind an external chain of serial-in, parallel-out shift registers. Each output channel has a 16-bit brightness word, of which the upper 14 bits are kept. The block rearranges these words into 14 bit-planes. A bit-plane is one 32-bit word that holds a single bit weight of every channel. The block then shows the planes one after the other, from the lowest weight to the highest. Each plane stays on the outputs for a time proportional to its weight, so the average on-time of an output follows its brightness value.

Each plane period has two timer cycles. In the data cycle, the plane is shifted out on a serial clock and data pair. The outputs stay blanked during the shift. When the compare point is reached, a latch strobe moves the shifted plane onto the outputs, and the plane is held until the cycle ends. The data-cycle length grows with the bit weight. A short clear cycle follows. The cycle lengths and compare points for the next cycle are loaded only when the current cycle rolls over, so the frame rate never changes.

Brightness values come in through a single-cycle write port and land in a shadow array. The shadow array is copied into the bit-plane buffer only when the highest-weight period has finished, so one frame never mixes old and new values.

Top module: `bcm_driver`

## Requirements
- R1: While reset is held, `blank` is 1, and `latch`, `ser_clk`, `ser_dat` and `overrun` are all 0. After reset, the block starts in the data cycle of plane 0, and all planes hold zero.
- R2: Plane p, bit c equals bit p+2 of the value last written to channel c. Bits 1 and 0 of a written value have no effect, and a later write to a channel replaces the earlier one.
- R3: A plane goes out as two 16-bit halves. Bits 15..0 go first, then bits 31..16, most significant bit first within each half. `ser_clk` is high for one clock at a time. `ser_dat` changes only while `ser_clk` is low, so the receiver samples on the rising edge.
- R4: Planes are shown in the order 0, 1, …, 13 and then return to plane 0.
- R5: The data cycle of plane p lasts 123 + (4 << p) clocks. This comes from an end count of 122 + (4 << p), which is a shift allowance of 120, plus a correction of 2, plus a base of 4 weighted by the bit.
- R6: Every clear cycle lasts 41 clocks, from an end count of 40.
- R7: `blank` is high during ticks 0..119 of a data cycle and during tick 0 of a clear cycle. `latch` rises 121 clocks after a data cycle starts and 2 clocks after a clear cycle starts. `latch` and `blank` are never high together.
- R8: A write changes nothing that is shown until the next frame boundary. Planes shown before that boundary keep their old content.
- R9: `overrun` sets, and stays set until reset, when a new shift starts while the shifter is busy, or when the shifter is still busy at the data-cycle compare tick. With the default parameters a shift takes 64 clocks, so `overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; one clock per tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Brightness write strobe |
| wr_addr | input | 5 | Channel number to write |
| wr_data | input | 16 | Brightness value; bits 1..0 ignored |
| ser_clk | output | 1 | Serial clock to the shift-register chain |
| ser_dat | output | 1 | Serial data to the shift-register chain |
| latch | output | 1 | Storage-register latch strobe |
| blank | output | 1 | Output clear / blank, active high |
| overrun | output | 1 | Sticky shift-timing error |

## Verification
A write appears on the serial line only from the first data cycle after the next frame boundary. A shift starts one clock into a data cycle and ends 64 clocks later. `latch` rises 121 clocks after `blank` rises at the start of a data cycle, and 2 clocks after a clear cycle starts. `overrun` is set one clock after the compare tick at which the shifter is still busy. The bench timestamps every rising edge of `blank` and `latch` on the falling clock edge and rebuilds each plane from `ser_dat` at each `ser_clk` rise. It checks cycle lengths and latch offsets as differences between those timestamps, and it checks each rebuilt word against the plane of the frame it falls in. This keeps every check in step with the cycle in which its result is due.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

   typedef enum logic {
      PH_DATA = 1'b0,
      PH_CLR  = 1'b1
   } bcm_phase_e;

   // End count of a data cycle: shift allowance + correction + weighted base
   function automatic int unsigned bcm_data_end(input int unsigned shift_tick,
                                                input int unsigned corr,
                                                input int unsigned base,
                                                input int unsigned bit_idx);
      return shift_tick + corr + (base << bit_idx);
   endfunction

endpackage

// File: rtl/bcm_planes.sv
module bcm_planes #(
   parameter int unsigned NCH    = 32,
   parameter int unsigned IN_W   = 16,
   parameter int unsigned DEPTH  = 14,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [IN_W-1:0]   wr_data,
   input  logic              load,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [NCH-1:0]    rd_word
);

   localparam int unsigned DROP = IN_W - DEPTH;

   logic [DEPTH-1:0] shadow_q [NCH];
   logic [NCH-1:0]   plane_nx [DEPTH];
   logic [NCH-1:0]   plane_q  [DEPTH];

   // shadow array: only the kept upper bits are stored
   for (genvar c = 0; c < NCH; c++) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q[c] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(c))) begin
            shadow_q[c] <= wr_data[IN_W-1:DROP];
         end
      end
   end

   // transpose: plane p collects bit p of every channel
   for (genvar p = 0; p < DEPTH; p++) begin : g_plane
      for (genvar c = 0; c < NCH; c++) begin : g_bit
         assign plane_nx[p][c] = shadow_q[c][p];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            plane_q[p] <= '0;
         end else if (load) begin
            plane_q[p] <= plane_nx[p];
         end
      end
   end

   assign rd_word = plane_q[rd_idx];

endmodule

// File: rtl/bcm_seq.sv
module bcm_seq
   import bcm_pkg::*;
#(
   parameter int unsigned DEPTH      = 14,
   parameter int unsigned SHIFT_TICK = 120,
   parameter int unsigned CORR       = 2,
   parameter int unsigned BASE       = 4,
   parameter int unsigned RST_LEN    = 40,
   parameter int unsigned CLR_TICK   = 1,
   parameter int unsigned DEAD       = 1,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned IDX_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             start,
   output logic             at_cmp,
   output logic             frame_wrap,
   output logic             latch,
   output logic             blank,
   output logic [IDX_W-1:0] idx
);

   localparam logic [CNT_W-1:0] RST_END  = CNT_W'(RST_LEN);
   localparam logic [CNT_W-1:0] CMP_DATA = CNT_W'(SHIFT_TICK);
   localparam logic [CNT_W-1:0] CMP_CLR  = CNT_W'(CLR_TICK);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
   localparam logic [CNT_W:0]   DEAD_EXT = (CNT_W+1)'(DEAD);

   logic [CNT_W-1:0] end_tbl [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
      assign end_tbl[i] = CNT_W'(bcm_data_end(SHIFT_TICK, CORR, BASE, i));
   end

   logic [CNT_W-1:0] cnt_q, end_q, cmp_q;
   bcm_phase_e       phase_q;
   logic [IDX_W-1:0] idx_q, idx_nx;
   logic             roll;

   assign roll = (cnt_q == end_q);

   always_comb begin
      idx_nx = idx_q;
      if (phase_q == PH_CLR) begin
         idx_nx = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end
   end

   // end count and compare are preloaded and take effect on rollover only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         end_q   <= end_tbl[0];
         cmp_q   <= CMP_DATA;
         phase_q <= PH_DATA;
         idx_q   <= '0;
      end else if (roll) begin
         cnt_q <= '0;
         idx_q <= idx_nx;
         if (phase_q == PH_DATA) begin
            phase_q <= PH_CLR;
            end_q   <= RST_END;
            cmp_q   <= CMP_CLR;
         end else begin
            phase_q <= PH_DATA;
            end_q   <= end_tbl[idx_nx];
            cmp_q   <= CMP_DATA;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // one compare channel drives the complementary pair with a dead gap
   assign blank      = (cnt_q < cmp_q);
   assign latch      = ({1'b0, cnt_q} >= ({1'b0, cmp_q} + DEAD_EXT));
   assign start      = (phase_q == PH_DATA) && (cnt_q == '0);
   assign at_cmp     = (phase_q == PH_DATA) && (cnt_q == cmp_q);
   assign frame_wrap = roll && (phase_q == PH_CLR) && (idx_q == LAST_IDX);
   assign idx        = idx_q;

endmodule

// File: rtl/bcm_shifter.sv
module bcm_shifter #(
   parameter int unsigned NCH    = 32,
   parameter int unsigned HALF_W = 16,
   parameter int unsigned POS_W  = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [NCH-1:0] word,
   output logic           ser_clk,
   output logic           ser_dat,
   output logic           busy
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(NCH - 1);

   logic [NCH-1:0]   word_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] sel;
   logic             clk_q, busy_q;

   // serial position -> word bit: halves low first, MSB first inside a half
   always_comb begin
      int unsigned p;
      p   = int'(pos_q);
      sel = POS_W'((p / HALF_W) * HALF_W + (HALF_W - 1 - (p % HALF_W)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         pos_q  <= '0;
         clk_q  <= 1'b0;
         busy_q <= 1'b0;
      end else if (start) begin
         word_q <= word;
         pos_q  <= '0;
         clk_q  <= 1'b0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (!clk_q) begin
            clk_q <= 1'b1;
         end else begin
            clk_q <= 1'b0;
            if (pos_q == LAST_POS) begin
               busy_q <= 1'b0;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
      end
   end

   assign ser_clk = clk_q;
   assign ser_dat = busy_q & word_q[sel];
   assign busy    = busy_q;

endmodule

// File: rtl/bcm_driver.sv
module bcm_driver
   import bcm_pkg::*;
#(
   parameter int unsigned NCH        = 32,
   parameter int unsigned IN_W       = 16,
   parameter int unsigned DEPTH      = 14,
   parameter int unsigned HALF_W     = 16,
   parameter int unsigned SHIFT_TICK = 120,
   parameter int unsigned CORR       = 2,
   parameter int unsigned BASE       = 4,
   parameter int unsigned RST_LEN    = 40,
   parameter int unsigned CLR_TICK   = 1,
   parameter int unsigned DEAD       = 1,
   localparam int unsigned ADDR_W    = $clog2(NCH),
   localparam int unsigned IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned POS_W     = $clog2(NCH),
   localparam int unsigned END_MAX   = bcm_data_end(SHIFT_TICK, CORR, BASE, DEPTH - 1),
   localparam int unsigned CNT_MAX   = (END_MAX > RST_LEN) ? END_MAX : RST_LEN,
   localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [IN_W-1:0]   wr_data,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              latch,
   output logic              blank,
   output logic              overrun
);

   // elaboration-time parameter checks
   if (NCH < 2) begin : g_bad_nch
      $error("bcm_driver: NCH must be at least 2");
   end
   if (DEPTH > IN_W) begin : g_bad_depth
      $error("bcm_driver: DEPTH must not exceed IN_W");
   end
   if ((NCH % HALF_W) != 0) begin : g_bad_half
      $error("bcm_driver: NCH must be a multiple of HALF_W");
   end
   if (DEAD < 1) begin : g_bad_dead
      $error("bcm_driver: DEAD must be at least 1");
   end
   if ((CLR_TICK + DEAD) > RST_LEN) begin : g_bad_clr
      $error("bcm_driver: clear compare plus dead time exceeds RST_LEN");
   end
   if ((SHIFT_TICK + DEAD) > bcm_data_end(SHIFT_TICK, CORR, BASE, 0)) begin : g_bad_data
      $error("bcm_driver: strobe point lies beyond the shortest data cycle");
   end

   logic             start, at_cmp, frame_wrap, shift_busy;
   logic [IDX_W-1:0] idx;
   logic [NCH-1:0]   plane_word;
   logic             overrun_q;

   bcm_seq #(
      .DEPTH     (DEPTH),
      .SHIFT_TICK(SHIFT_TICK),
      .CORR      (CORR),
      .BASE      (BASE),
      .RST_LEN   (RST_LEN),
      .CLR_TICK  (CLR_TICK),
      .DEAD      (DEAD),
      .CNT_W     (CNT_W),
      .IDX_W     (IDX_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .at_cmp    (at_cmp),
      .frame_wrap(frame_wrap),
      .latch     (latch),
      .blank     (blank),
      .idx       (idx)
   );

   bcm_planes #(
      .NCH   (NCH),
      .IN_W  (IN_W),
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .IDX_W (IDX_W)
   ) planes_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .load   (frame_wrap),
      .rd_idx (idx),
      .rd_word(plane_word)
   );

   bcm_shifter #(
      .NCH   (NCH),
      .HALF_W(HALF_W),
      .POS_W (POS_W)
   ) shift_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .word   (plane_word),
      .ser_clk(ser_clk),
      .ser_dat(ser_dat),
      .busy   (shift_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun_q <= 1'b0;
      end else if (shift_busy && (start || at_cmp)) begin
         overrun_q <= 1'b1;
      end
   end

   assign overrun = overrun_q;

endmodule

// File: rtl/bcm_driver_chk.sv
module bcm_driver_chk (
   input logic clk,
   input logic rst_n,
   input logic latch,
   input logic blank,
   input logic ser_clk,
   input logic ser_dat,
   input logic overrun,
   input logic shift_busy
);

   // R7
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(latch && blank));

   // R3
   sclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |=> !ser_clk);

   // R3
   dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> $stable(ser_dat));

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R9
   busy_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(latch) && shift_busy) |-> overrun);

endmodule

bind bcm_driver bcm_driver_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .latch     (latch),
   .blank     (blank),
   .ser_clk   (ser_clk),
   .ser_dat   (ser_dat),
   .overrun   (overrun),
   .shift_busy(shift_busy)
);

// File: tb/bcm_driver_tb.sv
module bcm_driver_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        ser_clk, ser_dat, latch, blank, overrun;
   logic        e_sclk, e_sdat, e_latch, e_blank, e_overrun;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int cyc = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   bcm_driver dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .latch(latch), .blank(blank), .overrun(overrun)
   );

   // strobe point too early for a 64-clock shift: must flag an overrun
   bcm_driver #(.SHIFT_TICK(40)) err_i (
      .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_addr(5'd0), .wr_data(16'd0),
      .ser_clk(e_sclk), .ser_dat(e_sdat), .latch(e_latch), .blank(e_blank), .overrun(e_overrun)
   );

   // ---------------- monitor ----------------
   int          ck_t [64];
   int          st_t [64];
   int          nck = 0, nst = 0, nw = 0, nb = 0;
   logic [31:0] words [40];
   logic [31:0] sh = '0;
   logic        blank_p = 1'b1, latch_p = 1'b0, sclk_p = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (blank && !blank_p && nck < 64) begin ck_t[nck] = cyc; nck++; end
         if (latch && !latch_p && nst < 64) begin st_t[nst] = cyc; nst++; end
         if (ser_clk && !sclk_p) begin
            sh = {sh[30:0], ser_dat};
            nb++;
            if (nb == 32) begin
               if (nw < 40) words[nw] = {sh[15:0], sh[31:16]};
               nw++;
               nb = 0;
            end
         end
      end
      blank_p = blank;
      latch_p = latch;
      sclk_p  = ser_clk;
   end

   // ---------------- helpers ----------------
   logic [15:0] val_a [32];
   logic [15:0] val_b [32];

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] plane_of(input logic [15:0] v [32], input int p);
      logic [31:0] r;
      for (int j = 0; j < 32; j++) r[j] = v[j][p+2];
      return r;
   endfunction

   task automatic wr(input int ch, input logic [15:0] v);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 5'(ch);
      wr_data = v;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_state();
      check(blank === 1'b1,   "R1 blank in reset",   32'(blank),   32'd1);
      check(latch === 1'b0,   "R1 latch in reset",   32'(latch),   32'd0);
      check(ser_clk === 1'b0, "R1 ser_clk in reset", 32'(ser_clk), 32'd0);
      check(ser_dat === 1'b0, "R1 ser_dat in reset", 32'(ser_dat), 32'd0);
      check(overrun === 1'b0, "R1 overrun in reset", 32'(overrun), 32'd0);
   endtask

   task automatic t_load_a();
      for (int j = 0; j < 32; j++)
         val_a[j] = 16'((j + 1) * 16'h2C9B) ^ 16'(j << 11);
      val_a[0]  = 16'hFFFF;
      val_a[31] = 16'h0003;   // R2: only ignored bits set
      wr(7, 16'hFFFF);        // R2: replaced by the later write
      for (int j = 0; j < 32; j++) wr(j, val_a[j]);
   endtask

   task automatic t_load_b_midframe();
      for (int j = 0; j < 32; j++) val_b[j] = ~val_a[j];
      for (int j = 0; j < 32; j++) wr(j, val_b[j]);
   endtask

   task automatic t_timing();
      for (int k = 1; k < 14; k++)
         check(ck_t[2*k] - ck_t[2*k-1] == 123 + (4 << k), "R5 data cycle length",
               32'(ck_t[2*k] - ck_t[2*k-1]), 32'(123 + (4 << k)));
      for (int k = 0; k < 14; k++)
         check(ck_t[2*k+1] - ck_t[2*k] == 41, "R6 clear cycle length",
               32'(ck_t[2*k+1] - ck_t[2*k]), 32'd41);
      check(ck_t[28] - ck_t[27] == 127, "R4 wrap to plane 0 length",
            32'(ck_t[28] - ck_t[27]), 32'd127);
      for (int k = 1; k < 4; k++) begin
         check(st_t[2*k] - ck_t[2*k-1] == 121, "R7 latch offset in data cycle",
               32'(st_t[2*k] - ck_t[2*k-1]), 32'd121);
         check(st_t[2*k+1] - ck_t[2*k] == 2, "R7 latch offset in clear cycle",
               32'(st_t[2*k+1] - ck_t[2*k]), 32'd2);
      end
   endtask

   task automatic t_frame0_zero();
      for (int k = 0; k < 14; k++)
         check(words[k] === 32'd0, "R8 frame 0 shows reset planes", words[k], 32'd0);
   endtask

   task automatic t_frame1_a();
      for (int k = 0; k < 14; k++)
         check(words[14+k] === plane_of(val_a, k), "R2 R3 R4 R8 frame 1 plane",
               words[14+k], plane_of(val_a, k));
   endtask

   task automatic t_frame2_b();
      for (int k = 0; k < 4; k++)
         check(words[28+k] === plane_of(val_b, k), "R8 new values after boundary",
               words[28+k], plane_of(val_b, k));
   endtask

   task automatic t_overrun();
      check(overrun === 1'b0,   "R9 no overrun with default timing", 32'(overrun), 32'd0);
      check(e_overrun === 1'b1, "R9 overrun with early strobe",      32'(e_overrun), 32'd1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      t_load_a();
      wait (nw >= 15);
      t_load_b_midframe();
      wait (nw >= 28 && nck >= 29);
      @(negedge clk);
      t_timing();
      t_frame0_zero();
      t_frame1_a();
      wait (nw >= 32);
      @(negedge clk);
      t_frame2_b();
      t_overrun();
      finish_run();
   end

   initial begin
      repeat (180000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<180000 cycles", cyc);
      finish_run();
   end

endmodule